// File: doc/BRIEF.md
# Four-Pin GPIO Port with Input Pullup Control

This block is a small bus-mapped general-purpose I/O port with four pins. Software reaches three byte-wide registers through a synchronous register interface: a pin value latch, a direction mask and an input pullup mask. For every pin the block drives an output value, an output enable and a pullup request toward the pad. It samples the pad level back through a two-flop synchronizer.

A read of the data address returns one of two values for each pin. An output pin returns the stored latch bit. An input pin returns the synchronized level on the pad. The latch accepts writes at any time, so software can preload a value before it switches a pin to output. A pullup is requested only for a pin that is an input with its pullup bit set. When a pin becomes an output, its pullup drops in the same cycle, without software action.

Top module: `gpio_pullup_port`

## Requirements
- R1: After reset the latch, direction and pullup registers are all zero. pin_oe, pin_out and pin_pu are 0, and reads of offsets 0x00, 0x04 and 0x0D return 0x00.
- R2: A read of offset 0x00 returns the latch bit for each pin whose direction bit is 1.
- R3: A read of offset 0x00 returns the pad level for each pin whose direction bit is 0, delayed by two clock edges. A pad change made before edge k shows in bus_rdata after edge k+1 and not before.
- R4: A write to offset 0x00 updates the latch bits 3:0 whatever the direction bits are. A value written while a pin is an input is held and does not alter what an input pin reads. It shows on pin_out and on reads once the pin is an output.
- R5: pin_oe equals the direction register (offset 0x04, bits 3:0, 1 = output), and pin_out equals the latch.
- R6: pin_pu[i] is 1 only when pullup bit i (offset 0x0D) is 1 and direction bit i is 0. Setting the direction bit clears pin_pu[i] on the same edge.
- R7: Bits 7:4 at offset 0x0D read 0, and writes to them are ignored.
- R8: The registers sit at offsets 0x00 (data), 0x04 (direction) and 0x0D (pullup). Bits 7:4 of the data and direction reads are 0. Reads of any other offset return 0x00, and writes to any other offset change no register.
- R9: A write takes effect on the rising clock edge where bus_we is 1. With bus_we at 0 no register changes. bus_rdata follows bus_addr combinationally within the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 4 | Pad input levels (asynchronous) |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables, 1 = drive |
| pin_pu | output | 4 | Pad pullup requests |

## Verification
The hardest situation to reach is a data read that mixes sources in one value: output pins show the latch while input pins show synchronized pad levels. The pad levels themselves depend on the pullup requests that the direction bits gate. The bench models the pad as a function of the block's own drive, an optional external driver and a pullup that reads 1 when undriven. Then it switches direction and pullup masks with the external driver on only some pins. It moves the external level one negedge before two reads in a row, to catch the exact two-edge synchronizer latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PUE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFS_DATA = 8'h00,
    parameter int OFS_DIR  = 8'h04,
    parameter int OFS_PUE  = 8'h0D
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_PUE  = ADDR_W'(OFS_PUE);

    always_comb begin
        sel = SEL_NONE;
        if (addr == A_DATA)     sel = SEL_DATA;
        else if (addr == A_DIR) sel = SEL_DIR;
        else if (addr == A_PUE) sel = SEL_PUE;
    end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  reg_sel_e            sel,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] latch,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] pue
);
    typedef struct packed {
        logic [NUM_PINS-1:0] latch;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] pue;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_PINS-1:0] wbits;

    assign wbits = wdata[NUM_PINS-1:0];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (sel)
                SEL_DATA: regs_d.latch = wbits;
                SEL_DIR:  regs_d.dir   = wbits;
                SEL_PUE:  regs_d.pue   = wbits;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign latch = regs_q.latch;
    assign dir   = regs_q.dir;
    assign pue   = regs_q.pue;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 4,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] async_in,
    output logic [NUM_PINS-1:0] sync_out
);
    logic [NUM_PINS-1:0] stage_d [STAGES];
    logic [NUM_PINS-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_in;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int OFS_DATA    = 8'h00,
    parameter int OFS_DIR     = 8'h04,
    parameter int OFS_PUE     = 8'h0D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pu
);
    localparam int PAD_W = DATA_W - NUM_PINS;

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] latch, dir, pue, pad_sync;
    logic [NUM_PINS-1:0] data_view;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .OFS_DATA(OFS_DATA), .OFS_DIR(OFS_DIR), .OFS_PUE(OFS_PUE)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_ctrl_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .we    (bus_we),
        .wdata (bus_wdata),
        .latch (latch),
        .dir   (dir),
        .pue   (pue)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pad_sync)
    );

    // per-pin source pick for the data view
    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_view
            assign data_view[i] = dir[i] ? latch[i] : pad_sync[i];
            assign pin_pu[i]    = pue[i] & ~dir[i];
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = {{PAD_W{1'b0}}, data_view};
            SEL_DIR:  bus_rdata = {{PAD_W{1'b0}}, dir};
            SEL_PUE:  bus_rdata = {{PAD_W{1'b0}}, pue};
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out = latch;
    assign pin_oe  = dir;
endmodule

// File: rtl/gpio_pullup_port_chk.sv
module gpio_pullup_port_chk #(
    parameter int NUM_PINS = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int OFS_DATA = 8'h00,
    parameter int OFS_DIR  = 8'h04,
    parameter int OFS_PUE  = 8'h0D
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_pu
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_PUE  = ADDR_W'(OFS_PUE);

    logic [1:0] cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cyc <= '0;
        else if (cyc != 3) cyc <= cyc + 2'd1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 0) |-> (pin_oe == '0 && pin_out == '0 && pin_pu == '0));

    assert_out_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DATA) |-> ((bus_rdata[NUM_PINS-1:0] & pin_oe) == (pin_out & pin_oe)));

    // synchronizer depth is fixed at two in this check (R3)
    assert_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2 && bus_addr == A_DATA) |->
        ((bus_rdata[NUM_PINS-1:0] & ~pin_oe) == ($past(pin_in, 2) & ~pin_oe)));

    assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DATA) |=> (pin_out == $past(bus_wdata[NUM_PINS-1:0])));

    assert_dir_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR) |=> (pin_oe == $past(bus_wdata[NUM_PINS-1:0])));

    assert_pullup_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    assert_pue_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PUE) |-> (bus_rdata[DATA_W-1:NUM_PINS] == '0));

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != A_DATA && bus_addr != A_DIR && bus_addr != A_PUE) |-> (bus_rdata == '0));

    assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)));
endmodule

bind gpio_pullup_port gpio_pullup_port_chk #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_DATA(OFS_DATA), .OFS_DIR(OFS_DIR), .OFS_PUE(OFS_PUE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/gpio_pullup_port_tb.sv
module gpio_pullup_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [3:0] pin_in, pin_out, pin_oe, pin_pu;
    logic [3:0] ext_en = '0;
    logic [3:0] ext_val = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t rd_q[$];

    always #2 clk = ~clk;

    // pad: own drive wins, else external driver, else pullup level (undriven reads 0)
    always_comb begin
        for (int i = 0; i < 4; i++)
            pin_in[i] = pin_oe[i] ? pin_out[i] : (ext_en[i] ? ext_val[i] : pin_pu[i]);
    end

    gpio_pullup_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    // driver: put the address out and push the expected value for the monitor
    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        rd_q.push_back(it);
        #2;
    endtask

    task automatic pins(input string tag, input logic [3:0] o, input logic [3:0] oe,
                        input logic [3:0] pu);
        check({tag, " pin_out"}, {4'h0, pin_out}, {4'h0, o});
        check({tag, " pin_oe"},  {4'h0, pin_oe},  {4'h0, oe});
        check({tag, " pin_pu"},  {4'h0, pin_pu},  {4'h0, pu});
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_q.size() > 0) begin
                rd_item_t it;
                it = rd_q.pop_front();
                check({it.tag, " read"}, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        pins("R1 reset", 4'h0, 4'h0, 4'h0);
        rd(8'h00, 8'h00, "R1 data");
        rd(8'h04, 8'h00, "R1 dir");
        rd(8'h0D, 8'h00, "R1 pue");

        // pullups on all inputs; upper write bits dropped
        wr(8'h0D, 8'hFF);
        pins("R6 pue on inputs", 4'h0, 4'h0, 4'hF);
        rd(8'h0D, 8'h0F, "R7 pue upper");
        repeat (3) @(negedge clk);
        rd(8'h00, 8'h0F, "R3 pulled inputs");

        // latch write while all inputs
        wr(8'h00, 8'hA5);
        pins("R4 latch held", 4'h5, 4'h0, 4'hF);
        rd(8'h00, 8'h0F, "R4 input unaffected");

        // pins 1:0 to output, upper dir bits dropped
        wr(8'h04, 8'hF3);
        pins("R6 auto off", 4'h5, 4'h3, 4'hC);
        rd(8'h04, 8'h03, "R8 dir upper");
        rd(8'h00, 8'h0D, "R2 mixed read");

        // R3 latency: drive pins 3:2 low externally
        @(negedge clk);
        ext_en = 4'hC; ext_val = 4'h0;
        rd(8'h00, 8'h0D, "R3 one edge old");
        rd(8'h00, 8'h01, "R3 two edges new");

        // R9: no write without we
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 8'hFF; bus_we = 1'b0;
        @(negedge clk);
        #1;
        pins("R9 no we", 4'h5, 4'h3, 4'hC);

        // unmapped offsets
        rd(8'h01, 8'h00, "R8 unmapped 01");
        rd(8'h0C, 8'h00, "R8 unmapped 0C");
        rd(8'hFF, 8'h00, "R8 unmapped FF");
        wr(8'h05, 8'hFF);
        pins("R8 unmapped write", 4'h5, 4'h3, 4'hC);

        // all outputs
        wr(8'h04, 8'h0F);
        pins("R5 all out", 4'h5, 4'hF, 4'h0);
        rd(8'h00, 8'h05, "R2 latch read");
        wr(8'h00, 8'h0A);
        pins("R4 out write", 4'hA, 4'hF, 4'h0);
        rd(8'h00, 8'h0A, "R2 latch read 2");

        // back to inputs: 3:2 driven low, 1:0 pulled up
        wr(8'h04, 8'h00);
        pins("R6 pu restored", 4'hA, 4'h0, 4'hF);
        repeat (3) @(negedge clk);
        rd(8'h00, 8'h03, "R3 inputs again");

        // pue upper only: all pullups cleared
        wr(8'h0D, 8'hF0);
        pins("R7 upper ignored", 4'hA, 4'h0, 4'h0);
        rd(8'h0D, 8'h00, "R7 pue read");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule